// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Model

This block is a synthesizable, cycle-based functional model of a 16-bit-wide asynchronous static RAM with an 18-bit word address. The block samples the active-low select, output-enable, write-enable and the two byte-lane enables on every clock edge. It decodes them into standby, read, write or output-disabled behaviour, separately for each byte lane. Each lane has an output-valid flag, so a surrounding model or bench can tell driven data from the high-impedance state without real tri-state logic.

The number of stored words is a parameter, so simulation stays small. Address bits above the stored range are ignored. A write is committed when it ends. A write ends when write-enable rises, the select rises or the lane's byte enable rises, whichever comes first. The data stored is the value that was present during the last active cycle. Reads are registered: the pins sampled at one edge set the outputs seen after that edge.

Top module: `bytelane_sram`

## Requirements
- R1: While and after reset, `lane_vld` is 2'b00 and `dout` is 16'h0000.
- R2: When the sampled pins give `ce_n`=0, `oe_n`=0 and `we_n`=1, then after that edge a lane drives stored data exactly when its enable is low. Lane 0 is bits 7:0, enabled by `lb_n`. Lane 1 is bits 15:8, enabled by `ub_n`. A lane that does not drive shows 8'h00 on `dout`.
- R3: With `ce_n`=1 no lane drives, and no write takes place, whatever the other pins are.
- R4: With `ce_n`=0 and `we_n`=0 no lane drives, for either level of `oe_n`.
- R5: With `ce_n`=0, `we_n`=1 and `oe_n`=1 no lane drives. With `ce_n`=0 and both byte enables high no lane drives.
- R6: A write stores only the lanes whose byte enable is low. The other lane of the stored word keeps its old value.
- R7: A write to a lane ends on the first sampled cycle in which `we_n`, `ce_n` or that lane's enable is high. The lane then holds the `din` value from the last cycle in which the write was active. Data presented after the write has ended is not stored.
- R8: A read sampled on the same edge that ends a write to the same address returns the newly written bytes.
- R9: Only the low log2(DEPTH) address bits select a word. With DEPTH=1024, address 18'h00405 reaches the same word as 18'h00005.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 18 | Word address |
| din | input | 16 | Write data |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Enable for bits 7:0, active low |
| ub_n | input | 1 | Enable for bits 15:8, active low |
| dout | output | 16 | Read data, zero on lanes that do not drive |
| lane_vld | output | 2 | Per-lane drive flag (bit 0 = low byte) |

## Verification
The properties assume that every pin is stable around the sampling edge. They also assume that the address stays constant while any write lane is active, because the model latches a single address for the write in progress. The stimulus changes pins only on the falling clock edge. It keeps the address fixed from the first active write cycle until the last lane has ended. It varies `din` only within those bounds, so that the end-of-write capture rule can be checked.

// File: rtl/bytelane_sram.sv
module bytelane_sram #(
  parameter int ADDR_W = 18,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              lb_n,
  input  logic              ub_n,
  output logic [15:0]       dout,
  output logic [1:0]        lane_vld
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LANES = 2;

  wire [IDX_W-1:0] idx = addr[IDX_W-1:0];
  wire unused_addr_hi = ^addr[ADDR_W-1:IDX_W];

  wire [LANES-1:0] be      = ~{ub_n, lb_n};
  wire             wr_mode = !ce_n && !we_n;
  wire             rd_mode = !ce_n && we_n && !oe_n;
  wire [LANES-1:0] wr_act  = {LANES{wr_mode}} & be;
  wire [LANES-1:0] rd_lane = {LANES{rd_mode}} & be;

  logic [LANES-1:0] act_q;
  logic [IDX_W-1:0] idx_q;
  logic [15:0]      data_q;
  wire  [LANES-1:0] commit = act_q & ~wr_act;

  logic [7:0] mem [DEPTH][LANES];
  logic [15:0] rd_next;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk)
        if (commit[l]) mem[idx_q][l] <= data_q[8*l +: 8];

      always_comb begin
        if (!rd_lane[l])
          rd_next[8*l +: 8] = 8'h00;
        else if (commit[l] && idx_q == idx)
          rd_next[8*l +: 8] = data_q[8*l +: 8];
        else
          rd_next[8*l +: 8] = mem[idx][l];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= '0;
      idx_q    <= '0;
      data_q   <= '0;
      lane_vld <= '0;
      dout     <= '0;
    end else begin
      act_q <= wr_act;
      if (|wr_act) begin
        idx_q  <= idx;
        data_q <= din;
      end
      lane_vld <= rd_lane;
      dout     <= rd_next;
    end
  end
endmodule

module bytelane_sram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n,
  input logic        oe_n,
  input logic        we_n,
  input logic        lb_n,
  input logic        ub_n,
  input logic [15:0] dout,
  input logic [1:0]  lane_vld
);
  // R2
  lo_drive_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_vld[0]) |-> $past(!ce_n && !oe_n && we_n && !lb_n));
  // R2
  hi_drive_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_vld[1]) |-> $past(!ce_n && !oe_n && we_n && !ub_n));
  // R2
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lane_vld[0] -> dout[7:0] == 8'h00) && (!lane_vld[1] -> dout[15:8] == 8'h00));
  // R3
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> lane_vld == 2'b00);
  // R4
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |=> lane_vld == 2'b00);
  // R5
  oe_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && oe_n) |=> lane_vld == 2'b00);
  // R5
  no_byte_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_n && ub_n) |=> lane_vld == 2'b00);
endmodule

bind bytelane_sram bytelane_sram_chk u_chk (.*);

// File: tb/sim_bytelane_sram.sv
module sim_bytelane_sram;
  logic clk = 0;
  logic rst_n = 0;
  logic [17:0] addr = '0;
  logic [15:0] din = '0;
  logic ce_n = 1, oe_n = 1, we_n = 1, lb_n = 1, ub_n = 1;
  logic [15:0] dout;
  logic [1:0]  lane_vld;

  int n_cmp = 0, n_bad = 0;
  logic [18:0] q_exp[$];
  string       q_req[$];

  always #4 clk = ~clk;

  bytelane_sram u0 (.clk, .rst_n, .addr, .din, .ce_n, .oe_n, .we_n,
                    .lb_n, .ub_n, .dout, .lane_vld);

  task automatic pins(input logic c, o, w, lb, ub, input logic [17:0] a,
                      input logic [15:0] d, input logic chk,
                      input logic [1:0] ev, input logic [15:0] ed, input string req);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; lb_n = lb; ub_n = ub; addr = a; din = d;
    q_exp.push_back({chk, ev, ed});
    q_req.push_back(req);
  endtask

  task automatic wr(input logic o, lb, ub, input logic [17:0] a, input logic [15:0] d, input string req);
    pins(0, o, 0, lb, ub, a, d, 1, 2'b00, 16'h0000, req);
  endtask

  task automatic rd(input logic lb, ub, input logic [17:0] a, input logic [1:0] ev,
                    input logic [15:0] ed, input string req);
    pins(0, 0, 1, lb, ub, a, 16'h0000, 1, ev, ed, req);
  endtask

  always @(posedge clk) begin
    #2;
    if (q_exp.size() != 0) begin
      logic [18:0] e;
      string r;
      e = q_exp.pop_front();
      r = q_req.pop_front();
      if (e[18]) begin
        n_cmp++;
        if (lane_vld !== e[17:16] || dout !== e[15:0]) begin
          n_bad++;
          $display("FAIL %s: vld=%b dout=%h expected vld=%b dout=%h",
                   r, lane_vld, dout, e[17:16], e[15:0]);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        n_cmp++;
        if (lane_vld !== 2'b00 || dout !== 16'h0000) begin
          n_bad++;
          $display("FAIL R1: vld=%b dout=%h expected vld=00 dout=0000", lane_vld, dout);
        end
        rst_n = 1;
        // R4 write both lanes with oe low, then R8 read on ending edge
        wr(0, 0, 0, 18'h5, 16'hA5C3, "R4");
        wr(1, 0, 0, 18'h5, 16'hA5C3, "R4");
        rd(0, 0, 18'h5, 2'b11, 16'hA5C3, "R8");
        // R6 upper-only write
        wr(1, 1, 0, 18'h5, 16'h1234, "R6");
        pins(0, 1, 1, 1, 1, 18'h5, 16'h0, 1, 2'b00, 16'h0000, "R5");
        rd(0, 0, 18'h5, 2'b11, 16'h12C3, "R6");
        rd(0, 1, 18'h5, 2'b01, 16'h00C3, "R2");
        rd(1, 0, 18'h5, 2'b10, 16'h1200, "R2");
        // R3 standby ignores write attempt
        pins(1, 0, 0, 0, 0, 18'h5, 16'hFFFF, 1, 2'b00, 16'h0000, "R3");
        pins(1, 0, 1, 0, 0, 18'h5, 16'hFFFF, 1, 2'b00, 16'h0000, "R3");
        rd(0, 0, 18'h5, 2'b11, 16'h12C3, "R3");
        // R5 output disables
        pins(0, 1, 1, 0, 0, 18'h5, 16'h0, 1, 2'b00, 16'h0000, "R5");
        pins(0, 0, 1, 1, 1, 18'h5, 16'h0, 1, 2'b00, 16'h0000, "R5");
        // R7 ended by chip select, last data wins
        wr(1, 0, 0, 18'h7, 16'h0BAD, "R7");
        wr(1, 0, 0, 18'h7, 16'h1111, "R7");
        pins(1, 1, 0, 0, 0, 18'h7, 16'h2222, 1, 2'b00, 16'h0000, "R7");
        rd(0, 0, 18'h7, 2'b11, 16'h1111, "R7");
        // R7 ended by byte enables
        wr(1, 0, 0, 18'h8, 16'h3344, "R7");
        pins(0, 1, 0, 1, 1, 18'h8, 16'h5566, 1, 2'b00, 16'h0000, "R7");
        rd(0, 0, 18'h8, 2'b11, 16'h3344, "R7");
        // R7 lanes ending at different cycles
        wr(1, 0, 0, 18'h9, 16'hAAAA, "R7");
        wr(1, 0, 1, 18'h9, 16'hBBBB, "R7");
        rd(0, 0, 18'h9, 2'b11, 16'hAABB, "R7");
        // R9 address aliasing
        wr(1, 0, 0, 18'h00405, 16'h7777, "R9");
        pins(0, 1, 1, 1, 1, 18'h5, 16'h0, 0, 2'b00, 16'h0000, "R9");
        rd(0, 0, 18'h5, 2'b11, 16'h7777, "R9");
        pins(1, 1, 1, 1, 1, 18'h0, 16'h0, 0, 2'b00, 16'h0000, "idle");
        repeat (3) @(negedge clk);
      end
      begin
        repeat (5000) @(negedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule